// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block gathers up to 32 level-sensitive request lines from peripherals and presents them to a processor on two outputs. One output is a fast interrupt line and the other is a normal interrupt line. Software uses a small word-addressed register port to route each source. A source can be a fast request, or it can be a normal request. A normal request can be tied to one of 16 numbered vector slots, or it can be left non-vectored. The slot number is the priority. Slot 0 is the highest and every non-vectored source sits below slot 15. Each slot carries a handler address, and all non-vectored sources share one default handler address.

The handler reads the vector register and gets the handler address of the best pending normal request. That read also records the request's priority level as in service. While a level is in service, only a normal request of strictly higher priority can raise the normal output again, so service nests. A write of any value to the vector register ends service of the most recent level. A pending fast request always owns the processor: it forces the normal output low, and the reverse never happens.

Top module: `intvec_ctrl`

## Requirements
- R1: After reset all enables, the fast-class bits, every source configuration, every slot address and the default address read as 0. Nothing is in service, and both interrupt outputs are low.
- R2: A write to address 0x03 sets the enable of every source whose data bit is 1. A write to 0x04 clears the enable of every source whose data bit is 1. Reading either address returns the current enable vector, with bit s belonging to source s.
- R3: Address 0x00 reads the raw request lines. Address 0x01 reads the requests ANDed with the enables. Address 0x02 reads the enabled requests that are of the fast class.
- R4: A source whose enable is 0 never causes the fast output or the normal output to go high.
- R5: Address 0x05 holds the class vector, with bit s equal to 1 meaning source s is fast. The fast output is high exactly when at least one enabled, requesting source is of the fast class.
- R6: The normal output is high exactly when an enabled, requesting normal-class source has a priority level strictly above the current in-service level and no fast request is active.
- R7: The configuration of source s is at address 0x20+s. Bits [3:0] hold the slot and bit 4 selects vectored. A vectored source has priority level equal to its slot, with 0 the highest. A non-vectored source has level 16, which is below every slot.
- R8: A read of address 0x06 returns the address stored for the best eligible source's slot. Slot k's address is kept at 0x10+k. The read returns the default address at 0x07 when the best eligible source is non-vectored or when none is eligible.
- R9: A read of 0x06 while some normal source is eligible marks that source's level as in service. From then on only strictly higher levels are eligible. A read with no eligible source changes nothing.
- R10: A write to 0x06 ends service of the highest-priority level in service, which is the one most recently entered. With nothing in service the write has no effect.
- R11: Nested service unwinds in order. After the inner level ends, the outer level again masks requests at or below its own priority. After the outer level ends, all levels are eligible again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_src | input | NSRC | Level request lines, one per source |
| reg_wr | input | 1 | Register write strobe, one cycle per access |
| reg_rd | input | 1 | Register read strobe, one cycle per access |
| reg_addr | input | 6 | Word address of the register |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr, valid in the same cycle |
| fiq_out | output | 1 | Fast interrupt request to the processor |
| irq_out | output | 1 | Normal interrupt request to the processor |

## Verification
The hardest state to reach from the ports is a deep in-service stack. Reaching it needs several vector reads, each taken while a request of strictly higher priority than the last is pending, and then pops interleaved with requests that appear and vanish. Some of those requests sit at the exact level being served, and some are fast requests that cut in.

A directed sequence builds two levels of nesting with a non-vectored request and a fast request in play. After that, a long run with a fixed seed mixes sparse request patterns, vector reads and writes, and configuration changes. A bench model of the in-service levels predicts both outputs and every returned address.

// File: rtl/intvec_pkg.sv
package intvec_pkg;
  localparam int SLOT_W   = 4;
  localparam int NSLOT    = 1 << SLOT_W;
  localparam int LVL_W    = $clog2(NSLOT + 2);
  localparam int DEPTH    = NSLOT + 1;
  localparam int ADDR_W   = 6;

  localparam logic [ADDR_W-1:0] A_RAW    = 6'h00;
  localparam logic [ADDR_W-1:0] A_MASKED = 6'h01;
  localparam logic [ADDR_W-1:0] A_FAST   = 6'h02;
  localparam logic [ADDR_W-1:0] A_ENSET  = 6'h03;
  localparam logic [ADDR_W-1:0] A_ENCLR  = 6'h04;
  localparam logic [ADDR_W-1:0] A_CLASS  = 6'h05;
  localparam logic [ADDR_W-1:0] A_VECT   = 6'h06;
  localparam logic [ADDR_W-1:0] A_DEFV   = 6'h07;
  localparam int                A_SLOT0  = 16;
  localparam int                A_CFG0   = 32;

  typedef struct packed {
    logic              vect;
    logic [SLOT_W-1:0] slot;
  } src_cfg_t;

  localparam int CFG_W = $bits(src_cfg_t);
  localparam logic [LVL_W-1:0] LVL_NONVEC = LVL_W'(NSLOT);
  localparam logic [LVL_W-1:0] LVL_IDLE   = LVL_W'(NSLOT + 1);

  // Priority level of a source: its slot when vectored, otherwise just below all slots.
  function automatic logic [LVL_W-1:0] cfg_level(src_cfg_t c);
    if (c.vect) return LVL_W'(c.slot);
    return LVL_NONVEC;
  endfunction

  // Clear the lowest set bit of an in-service mask (the highest-priority level).
  function automatic logic [DEPTH-1:0] drop_lowest(logic [DEPTH-1:0] m);
    return m & (m - DEPTH'(1));
  endfunction
endpackage

// File: rtl/intvec_regs.sv
module intvec_regs
  import intvec_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int DW   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdata,
  output logic [NSRC-1:0]   en,
  output logic [NSRC-1:0]   cls,
  output src_cfg_t          cfg       [NSRC],
  output logic [DW-1:0]     slot_addr [NSLOT],
  output logic [DW-1:0]     def_addr,
  output logic [DW-1:0]     cfg_rdata
);
  logic [NSRC-1:0] wbits;
  assign wbits = wdata[NSRC-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en       <= '0;
      cls      <= '0;
      def_addr <= '0;
      for (int i = 0; i < NSRC; i++)  cfg[i]       <= '0;
      for (int k = 0; k < NSLOT; k++) slot_addr[k] <= '0;
    end else if (wr) begin
      if (addr == A_ENSET) en       <= en | wbits;
      if (addr == A_ENCLR) en       <= en & ~wbits;
      if (addr == A_CLASS) cls      <= wbits;
      if (addr == A_DEFV)  def_addr <= wdata;
      for (int k = 0; k < NSLOT; k++)
        if (addr == ADDR_W'(A_SLOT0 + k)) slot_addr[k] <= wdata;
      for (int i = 0; i < NSRC; i++)
        if (addr == ADDR_W'(A_CFG0 + i)) cfg[i] <= wdata[CFG_W-1:0];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    if (addr == A_ENSET || addr == A_ENCLR) cfg_rdata = DW'(en);
    if (addr == A_CLASS) cfg_rdata = DW'(cls);
    if (addr == A_DEFV)  cfg_rdata = def_addr;
    for (int k = 0; k < NSLOT; k++)
      if (addr == ADDR_W'(A_SLOT0 + k)) cfg_rdata = slot_addr[k];
    for (int i = 0; i < NSRC; i++)
      if (addr == ADDR_W'(A_CFG0 + i)) cfg_rdata = DW'(cfg[i]);
  end

  // R2: every bit named by a clear write is off afterwards
  assert_enable_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == A_ENCLR) |=> ((en & $past(wbits)) == '0));
endmodule

// File: rtl/intvec_arb.sv
module intvec_arb
  import intvec_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NSRC-1:0]            elig,
  input  logic [NSRC-1:0][LVL_W-1:0] lvl,
  input  logic [LVL_W-1:0]           cur_lvl,
  output logic                       win_valid,
  output logic [LVL_W-1:0]           win_lvl
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;
  logic [IDX_W-1:0] win_idx;

  // Strict compare keeps the lowest source number among equal levels.
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = LVL_IDLE;
    for (int s = 0; s < NSRC; s++) begin
      if (elig[s] && (lvl[s] < cur_lvl) && (lvl[s] < win_lvl)) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(s);
        win_lvl   = lvl[s];
      end
    end
  end

  // R9: a winner is always a pending source strictly above the in-service level
  assert_winner_above_service_R9: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> (elig[win_idx] && (lvl[win_idx] < cur_lvl)));
endmodule

// File: rtl/intvec_stack.sv
module intvec_stack
  import intvec_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LVL_W-1:0] push_lvl,
  input  logic             pop,
  output logic [LVL_W-1:0] cur_lvl
);
  localparam logic [DEPTH-1:0] ONE = DEPTH'(1);
  logic [DEPTH-1:0] mask;

  // Nesting only ever enters a higher priority, so the lowest set bit is the top.
  always_comb begin
    cur_lvl = LVL_IDLE;
    for (int l = DEPTH - 1; l >= 0; l--)
      if (mask[l]) cur_lvl = LVL_W'(l);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    mask <= '0;
    else if (pop)  mask <= drop_lowest(mask);
    else if (push) mask <= mask | (ONE << push_lvl);
  end

  // R9: each accepted vector read adds exactly one level
  assert_push_adds_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> ($countones(mask) == $past($countones(mask)) + 1));
  // R10: an end-of-service write removes exactly one level when any is held
  assert_pop_removes_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && mask != '0) |=> ($countones(mask) + 1 == $past($countones(mask))));
endmodule

// File: rtl/intvec_ctrl.sv
module intvec_ctrl
  import intvec_pkg::*;
#(
  parameter int NSRC = 32,
  parameter int DW   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_src,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              fiq_out,
  output logic              irq_out
);
  logic [NSRC-1:0]            en, cls;
  src_cfg_t                   cfg       [NSRC];
  logic [DW-1:0]              slot_addr [NSLOT];
  logic [DW-1:0]              def_addr, cfg_rdata, vec_data;
  logic [NSRC-1:0]            masked, fast_pend, norm_pend;
  logic [NSRC-1:0][LVL_W-1:0] src_lvl;
  logic [LVL_W-1:0]           cur_lvl, win_lvl;
  logic                       win_valid, vec_rd, vec_wr, push;

  intvec_regs #(.NSRC(NSRC), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .en(en), .cls(cls), .cfg(cfg), .slot_addr(slot_addr), .def_addr(def_addr),
    .cfg_rdata(cfg_rdata)
  );

  assign masked    = irq_src & en;
  assign fast_pend = masked & cls;
  assign norm_pend = masked & ~cls;

  for (genvar g = 0; g < NSRC; g++) begin : g_lvl
    assign src_lvl[g] = cfg_level(cfg[g]);
  end

  intvec_arb #(.NSRC(NSRC)) u_arb (
    .clk(clk), .rst_n(rst_n), .elig(norm_pend), .lvl(src_lvl), .cur_lvl(cur_lvl),
    .win_valid(win_valid), .win_lvl(win_lvl)
  );

  assign vec_rd = reg_rd && (reg_addr == A_VECT);
  assign vec_wr = reg_wr && (reg_addr == A_VECT);
  assign push   = vec_rd && win_valid && !vec_wr;

  intvec_stack u_stack (
    .clk(clk), .rst_n(rst_n), .push(push), .push_lvl(win_lvl), .pop(vec_wr),
    .cur_lvl(cur_lvl)
  );

  assign fiq_out  = |fast_pend;
  assign irq_out  = win_valid && !fiq_out;
  assign vec_data = (win_valid && win_lvl < LVL_NONVEC) ? slot_addr[win_lvl[SLOT_W-1:0]]
                                                        : def_addr;

  always_comb begin
    case (reg_addr)
      A_RAW:    reg_rdata = DW'(irq_src);
      A_MASKED: reg_rdata = DW'(masked);
      A_FAST:   reg_rdata = DW'(fast_pend);
      A_VECT:   reg_rdata = vec_data;
      default:  reg_rdata = cfg_rdata;
    endcase
  end

  // R4: with every request line masked off, neither output rises
  assert_disabled_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (masked == '0) |-> (!fiq_out && !irq_out));
  // R6: a fast request and a normal request are never presented together
  assert_fast_blocks_normal_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_out |-> !irq_out);
endmodule

// File: tb/sim_intvec_ctrl.sv
`timescale 1ns/1ps
module sim_intvec_ctrl;
  import intvec_pkg::*;
  localparam int NSRC = 32;
  localparam int DW   = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0]   irq_src = '0;
  logic              reg_wr = 1'b0, reg_rd = 1'b0;
  logic [ADDR_W-1:0] reg_addr = '0;
  logic [DW-1:0]     reg_wdata = '0;
  logic [DW-1:0]     reg_rdata;
  logic              fiq_out, irq_out;

  always #2.5 clk = ~clk;

  intvec_ctrl #(.NSRC(NSRC), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fiq_out(fiq_out), .irq_out(irq_out)
  );

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;

  // Bench model of the programmer-visible state
  logic [NSRC-1:0] m_en = '0, m_cls = '0;
  logic [4:0]      m_cfg  [NSRC];
  logic [DW-1:0]   m_slot [16];
  logic [DW-1:0]   m_def = '0;
  logic [16:0]     m_isr = '0;

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int f_level(int s);
    return m_cfg[s][4] ? int'(m_cfg[s][3:0]) : 16;
  endfunction

  function automatic int f_cur();
    for (int l = 0; l < 17; l++) if (m_isr[l]) return l;
    return 17;
  endfunction

  function automatic int f_win();
    int best = -1, bl = 99, cur = f_cur();
    for (int s = 0; s < NSRC; s++)
      if (irq_src[s] && m_en[s] && !m_cls[s] && f_level(s) < cur && f_level(s) < bl) begin
        best = s; bl = f_level(s);
      end
    return best;
  endfunction

  function automatic logic f_fiq();
    return |(irq_src & m_en & m_cls);
  endfunction

  function automatic logic f_irq();
    return (f_win() >= 0) && !f_fiq();
  endfunction

  task automatic check_lines(string req);
    check({req, " fast"}, DW'(fiq_out), DW'(f_fiq()));
    check({req, " normal"}, DW'(irq_out), DW'(f_irq()));
  endtask

  task automatic bus_write(logic [ADDR_W-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #0.5 reg_wr = 1'b0;
    if (a == A_ENSET) m_en = m_en | d;
    else if (a == A_ENCLR) m_en = m_en & ~d;
    else if (a == A_CLASS) m_cls = d;
    else if (a == A_DEFV) m_def = d;
    else if (a == A_VECT) m_isr = m_isr & (m_isr - 17'd1);
    else if (a[5:4] == 2'b01) m_slot[a[3:0]] = d;
    else if (a[5]) m_cfg[a[4:0]] = d[4:0];
  endtask

  task automatic bus_read(logic [ADDR_W-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk);
    #0.5 reg_rd = 1'b0;
  endtask

  task automatic vec_read(string req);
    logic [DW-1:0] d, e;
    int w;
    w = f_win();
    e = (w >= 0 && f_level(w) < 16) ? m_slot[f_level(w)] : m_def;
    bus_read(A_VECT, d);
    check(req, d, e);
    if (w >= 0) m_isr[f_level(w)] = 1'b1;
  endtask

  task automatic set_src(logic [NSRC-1:0] v);
    @(negedge clk);
    irq_src = v;
    #1;
  endtask

  task automatic read_check(string req, logic [ADDR_W-1:0] a, logic [DW-1:0] e);
    logic [DW-1:0] d;
    bus_read(a, d);
    check(req, d, e);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #500000;
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    logic [DW-1:0] d;
    void'($urandom(32'd20240611));
    for (int i = 0; i < NSRC; i++) m_cfg[i] = '0;
    for (int k = 0; k < 16; k++) m_slot[k] = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;

    // R1: reset state
    check_lines("R1");
    read_check("R1 enables", A_ENSET, 32'h0);
    read_check("R1 class", A_CLASS, 32'h0);
    read_check("R1 default", A_DEFV, 32'h0);
    read_check("R1 slot5", 6'h15, 32'h0);
    read_check("R1 cfg7", 6'h27, 32'h0);
    vec_read("R1 vector idle");

    // R2: set and clear enables
    bus_write(A_ENSET, 32'hF0F0_000F);
    read_check("R2 set", A_ENSET, 32'hF0F0_000F);
    bus_write(A_ENCLR, 32'h0000_0005);
    read_check("R2 clear", A_ENCLR, 32'hF0F0_000A);

    // R3: status views
    set_src(32'hA5A5_3C3C);
    read_check("R3 raw", A_RAW, 32'hA5A5_3C3C);
    read_check("R3 masked", A_MASKED, 32'hA5A5_3C3C & m_en);
    read_check("R3 fast", A_FAST, 32'h0);

    // Configuration for the directed nesting sequence
    bus_write(A_ENCLR, 32'hFFFF_FFFF);
    for (int k = 0; k < 16; k++) bus_write(ADDR_W'(A_SLOT0 + k), 32'h1000 + 32'(k) * 16);
    bus_write(A_DEFV, 32'hDEAD_0000);
    bus_write(6'h24, 32'h17);  // source 4: slot 7
    bus_write(6'h2A, 32'h11);  // source 10: slot 1
    bus_write(6'h2C, 32'h10);  // source 12: slot 0
    bus_write(6'h34, 32'h00);  // source 20: non-vectored
    bus_write(A_CLASS, 32'h0000_0008);
    bus_write(A_ENSET, 32'h0010_1418);
    read_check("R7 cfg readback", 6'h2A, 32'h11);

    // R4: only disabled sources request
    set_src(32'h0000_0003);
    check_lines("R4");
    check("R4 normal low", DW'(irq_out), 32'h0);

    // R8, R9, R10 with a non-vectored source
    set_src(32'h0010_0000);
    check_lines("R6");
    vec_read("R8 default address");
    check_lines("R9 same level masked");
    bus_write(A_VECT, 32'h0);
    check_lines("R10 pop");
    bus_write(A_VECT, 32'h0);
    check_lines("R10 empty pop");

    // R7 and R11: priority choice and nesting
    set_src(32'h0010_0410);
    vec_read("R7 slot1 beats slot7");
    check_lines("R9 lower masked");
    set_src(32'h0010_1410);
    check("R9 higher raises", DW'(irq_out), 32'h1);
    vec_read("R11 inner slot0");
    check_lines("R11 inner");
    set_src(32'h0010_1418);
    check_lines("R5");
    check("R5 fast high", DW'(fiq_out), 32'h1);
    set_src(32'h0010_1410);
    bus_write(A_VECT, 32'h0);
    check_lines("R11 back to outer");
    set_src(32'h0010_0410);
    check("R11 outer masks", DW'(irq_out), 32'h0);
    bus_write(A_VECT, 32'h0);
    check_lines("R11 all clear");
    vec_read("R11 reentry");
    bus_write(A_VECT, 32'h0);

    // Mixed random phase
    for (int it = 0; it < 600; it++) begin
      int op;
      op = int'($urandom % 10);
      case (op)
        0, 1, 2: set_src($urandom & $urandom & $urandom);
        3: vec_read("R8 random vector");
        4: bus_write(A_VECT, $urandom);
        5: bus_write(ADDR_W'(A_CFG0 + int'($urandom % NSRC)), $urandom);
        6: bus_write(A_ENSET, $urandom & $urandom);
        7: bus_write(A_ENCLR, $urandom & $urandom);
        8: bus_write(A_CLASS, $urandom & $urandom & $urandom);
        default: begin
          read_check("R3 random raw", A_RAW, irq_src);
          read_check("R3 random masked", A_MASKED, irq_src & m_en);
          read_check("R3 random fast", A_FAST, irq_src & m_en & m_cls);
          read_check("R2 random enables", A_ENSET, m_en);
        end
      endcase
      check_lines("R6 random");
    end

    bus_read(A_RAW, d);
    check("R3 final raw", d, irq_src);
    finished = 1'b1;
    finish_run();
  end
endmodule